// File: doc/BRIEF.md
# Link-Event Interrupt Controller

This block sits beside a copper Ethernet PHY's management logic and turns changes in the PHY's link status word into interrupt events. Every cycle it compares the live status word with the copy it captured on the previous cycle. A difference in the link-up flag, the speed code or the duplex flag latches the matching event bit. Three further sources enter as single-cycle pulses: negotiation finished, automatic speed downgrade and wake packet seen.

Pending events collect in a status register. Reading that register returns its contents and clears it. A separate enable mask decides which pending events pull the active-low interrupt line. Software reaches the registers through a plain read/write port with 5-bit addresses:

| Address | Register |
|---------|----------|
| 0x18 | Live link status word |
| 0x19 | Enable mask |
| 0x1A | Pending events |

Top module: `link_event_irq`

## Requirements
- R1: After reset the mask and the pending register are zero, `irqN` is high and `regRdData` is zero. The first link word sampled after reset is only a baseline, so whatever its value it raises no change event.
- R2: A change of link status bit 10 (1 = link up) between two consecutive sampled words sets pending bit 0.
- R3: A change of the speed code in link status bits 2:0 between two consecutive sampled words sets pending bit 1. The codes are 0 = 10M, 1 = 100M, 2 = 1000M and 4 = 2500M.
- R4: A change of link status bit 3 (1 = full duplex) between two consecutive sampled words sets pending bit 2.
- R5: A pulse on `extEvt[0]` (negotiation done) sets pending bit 10. A pulse on `extEvt[1]` (speed downgrade) sets pending bit 5. A pulse on `extEvt[2]` (wake packet) sets pending bit 15.
- R6: A read of address 0x1A returns the pending bits on `regRdData` in the next cycle and clears them all. If no new event arrives, `irqN` is high in the cycle after the read.
- R7: An event that arrives in the same cycle as a pending-register read is not part of the returned value. It stays pending for the next read.
- R8: Pending bits latch even when masked. With the mask at zero, `irqN` stays high. Enabling a bit that is already pending drives `irqN` low in the cycle right after the write.
- R9: `irqN` is low exactly while some pending bit is also set in the mask.
- R10: Only mask bits 0, 1, 2, 5, 10 and 15 (0x8427) store a written value; all other mask bits read as 0. Address 0x18 reads the live link word. Unmapped addresses read 0. Writes to any address other than 0x19 change nothing.
- R11: Changes in link word bits other than 10, 3 and 2:0 raise no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| linkWord | input | 16 | Live link status word from the PHY |
| extEvt | input | 3 | Event pulses: [0] negotiation done, [1] speed downgrade, [2] wake packet |
| regAddr | input | 5 | Register address |
| regWrEn | input | 1 | Write strobe |
| regRdEn | input | 1 | Read strobe |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data, valid the cycle after `regRdEn` |
| irqN | output | 1 | Active-low interrupt |

## Verification
The properties assume the following about the inputs:
- A read and a write never share a cycle.
- `linkWord` is a synchronous value that is sampled once per clock.
- External events are pulses of one cycle.

The read-clears check applies only in cycles where the link word matches the checker's own previous copy and no pulse is present, so it never has to reason about an event landing during the read. The stimulus keeps every register access to a single strobe. It changes the link word only on the falling edge and clears every pulse after one cycle. It also places a deliberate pulse in a read cycle to exercise the case that the read-clears check leaves out.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  localparam int WORD_W = 16;

  // Link status word layout
  localparam int LS_LINK_BIT = 10;
  localparam int LS_DPX_BIT  = 3;
  localparam int LS_SPD_LSB  = 0;
  localparam int LS_SPD_W    = 3;

  // Event bit positions in the pending and mask registers
  localparam int EV_LINK      = 0;
  localparam int EV_SPEED     = 1;
  localparam int EV_DUPLEX    = 2;
  localparam int EV_DOWNSHIFT = 5;
  localparam int EV_ANDONE    = 10;
  localparam int EV_WAKE      = 15;

  localparam int N_EXT = 3;

  // Bit position fed by each external pulse input
  function automatic int extPos(input int idx);
    case (idx)
      0:       return EV_ANDONE;
      1:       return EV_DOWNSHIFT;
      default: return EV_WAKE;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] legalMask();
    logic [WORD_W-1:0] m;
    m = '0;
    m[EV_LINK]   = 1'b1;
    m[EV_SPEED]  = 1'b1;
    m[EV_DUPLEX] = 1'b1;
    for (int i = 0; i < N_EXT; i++) m[extPos(i)] = 1'b1;
    return m;
  endfunction

  // Strobes from control to datapath
  typedef struct packed {
    logic detEn;
    logic wrMask;
    logic rdAny;
    logic rdLink;
    logic rdMask;
    logic rdStat;
  } regStrobe_t;
endpackage

// File: rtl/lirq_ctrl.sv
module lirq_ctrl
  import lirq_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int ADDR_LINK = 'h18,
  parameter int ADDR_MASK = 'h19,
  parameter int ADDR_STAT = 'h1A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  output regStrobe_t        strb
);
  localparam logic [ADDR_W-1:0] A_LINK = ADDR_W'(ADDR_LINK);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(ADDR_MASK);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);

  // Set after the first sampled link word, which is only a baseline
  logic armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  always_comb begin
    strb.detEn  = armed;
    strb.wrMask = regWrEn && (regAddr == A_MASK);
    strb.rdAny  = regRdEn;
    strb.rdLink = regRdEn && (regAddr == A_LINK);
    strb.rdMask = regRdEn && (regAddr == A_MASK);
    strb.rdStat = regRdEn && (regAddr == A_STAT);
  end
endmodule

// File: rtl/lirq_detect.sv
module lirq_detect
  import lirq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              detEn,
  input  logic [WORD_W-1:0] linkWord,
  input  logic [N_EXT-1:0]  extEvt,
  output logic [WORD_W-1:0] evtVec
);
  logic [WORD_W-1:0] prevWord;
  logic [WORD_W-1:0] extPart [N_EXT];
  logic [WORD_W-1:0] chgVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevWord <= '0;
    else       prevWord <= linkWord;
  end

  // Per-pulse placement into the event vector
  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    assign extPart[g] = extEvt[g] ? (WORD_W'(1) << extPos(g)) : '0;
  end

  always_comb begin
    chgVec = '0;
    if (detEn) begin
      chgVec[EV_LINK]   = linkWord[LS_LINK_BIT] ^ prevWord[LS_LINK_BIT];
      chgVec[EV_SPEED]  = linkWord[LS_SPD_LSB +: LS_SPD_W] != prevWord[LS_SPD_LSB +: LS_SPD_W];
      chgVec[EV_DUPLEX] = linkWord[LS_DPX_BIT] ^ prevWord[LS_DPX_BIT];
    end
    evtVec = chgVec;
    for (int i = 0; i < N_EXT; i++) evtVec = evtVec | extPart[i];
  end
endmodule

// File: rtl/lirq_regs.sv
module lirq_regs
  import lirq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [WORD_W-1:0] evtVec,
  input  logic [WORD_W-1:0] linkWord,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  output logic [WORD_W-1:0] statVec,
  output logic [WORD_W-1:0] maskVec,
  output logic              irqN
);
  localparam logic [WORD_W-1:0] LEGAL = legalMask();

  logic [WORD_W-1:0] statNext;
  logic [WORD_W-1:0] rdMux;

  // New events survive a clearing read in the same cycle
  assign statNext = (strb.rdStat ? '0 : statVec) | (evtVec & LEGAL);

  always_comb begin
    rdMux = '0;
    if      (strb.rdLink) rdMux = linkWord;
    else if (strb.rdMask) rdMux = maskVec;
    else if (strb.rdStat) rdMux = statVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statVec   <= '0;
      maskVec   <= '0;
      regRdData <= '0;
    end else begin
      statVec <= statNext;
      if (strb.wrMask) maskVec   <= regWrData & LEGAL;
      if (strb.rdAny)  regRdData <= rdMux;
    end
  end

  assign irqN = ~|(statVec & maskVec);
endmodule

// File: rtl/link_event_irq.sv
module link_event_irq
  import lirq_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int ADDR_LINK = 'h18,
  parameter int ADDR_MASK = 'h19,
  parameter int ADDR_STAT = 'h1A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       linkWord,
  input  logic [2:0]        extEvt,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [15:0]       regWrData,
  output logic [15:0]       regRdData,
  output logic              irqN
);
  regStrobe_t        strb;
  logic [WORD_W-1:0] evtVec;
  logic [WORD_W-1:0] statVec;
  logic [WORD_W-1:0] maskVec;

  lirq_ctrl #(
    .ADDR_W(ADDR_W), .ADDR_LINK(ADDR_LINK),
    .ADDR_MASK(ADDR_MASK), .ADDR_STAT(ADDR_STAT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .strb(strb)
  );

  lirq_detect u_det (
    .clk(clk), .rstN(rstN), .detEn(strb.detEn),
    .linkWord(linkWord), .extEvt(extEvt), .evtVec(evtVec)
  );

  lirq_regs u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .evtVec(evtVec),
    .linkWord(linkWord), .regWrData(regWrData), .regRdData(regRdData),
    .statVec(statVec), .maskVec(maskVec), .irqN(irqN)
  );
endmodule

// File: rtl/lirq_checker.sv
module lirq_checker
  import lirq_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int ADDR_MASK = 'h19,
  parameter int ADDR_STAT = 'h1A
) (
  input logic              clk,
  input logic              rstN,
  input logic [15:0]       linkWord,
  input logic [2:0]        extEvt,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [15:0]       regWrData,
  input logic [15:0]       regRdData,
  input logic              irqN,
  input logic [15:0]       statVec,
  input logic [15:0]       maskVec
);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(ADDR_MASK);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);

  logic        armedC;
  logic [15:0] prevC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedC <= 1'b0;
      prevC  <= '0;
    end else begin
      armedC <= 1'b1;
      prevC  <= linkWord;
    end
  end

  p_no_base_evt_r1: assert property (@(posedge clk) disable iff (!rstN)
    !armedC |=> statVec[2:0] == 3'b000);

  p_link_evt_r2: assert property (@(posedge clk) disable iff (!rstN)
    (armedC && linkWord[10] != prevC[10]) |=> statVec[0]);

  p_speed_evt_r3: assert property (@(posedge clk) disable iff (!rstN)
    (armedC && linkWord[2:0] != prevC[2:0]) |=> statVec[1]);

  p_rd_data_r6: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == A_STAT) |=> regRdData == $past(statVec));

  p_rd_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && !regWrEn && regAddr == A_STAT && extEvt == 3'b000 &&
     (!armedC || linkWord == prevC)) |=> (statVec == 16'h0000 && irqN));

  p_wake_kept_r7: assert property (@(posedge clk) disable iff (!rstN)
    extEvt[2] |=> statVec[15]);

  p_mask_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == A_MASK && regWrData == 16'h0000) |=> irqN);

  p_mask_legal_r10: assert property (@(posedge clk) disable iff (!rstN)
    (maskVec & ~legalMask()) == 16'h0000);
endmodule

bind link_event_irq lirq_checker #(
  .ADDR_W(ADDR_W), .ADDR_MASK(ADDR_MASK), .ADDR_STAT(ADDR_STAT)
) u_chk (
  .clk(clk), .rstN(rstN), .linkWord(linkWord), .extEvt(extEvt),
  .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regWrData(regWrData), .regRdData(regRdData), .irqN(irqN),
  .statVec(statVec), .maskVec(maskVec)
);

// File: tb/sim_link_event_irq.sv
`timescale 1ns/1ps
module sim_link_event_irq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] lw = 16'h0402;
  logic [2:0]  ext = 3'b000;
  logic [4:0]  addr = 5'h00;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [15:0] wd = 16'h0000;
  logic [15:0] regRdData;
  logic        irqN;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Reference model state
  logic [15:0] mStat = '0, mMask = '0, mPrev = '0, mRd = '0;
  bit          mBase = 0;

  always #5 clk = ~clk;

  link_event_irq u0 (
    .clk(clk), .rstN(rstN), .linkWord(lw), .extEvt(ext),
    .regAddr(addr), .regWrEn(wr), .regRdEn(rd), .regWrData(wd),
    .regRdData(regRdData), .irqN(irqN)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelStep();
    logic [15:0] evt;
    evt = '0;
    if (mBase) begin
      evt[0] = lw[10] ^ mPrev[10];
      evt[1] = lw[2:0] != mPrev[2:0];
      evt[2] = lw[3] ^ mPrev[3];
    end
    if (ext[0]) evt[10] = 1'b1;
    if (ext[1]) evt[5]  = 1'b1;
    if (ext[2]) evt[15] = 1'b1;
    if (rd) begin
      case (addr)
        5'h18:   mRd = lw;
        5'h19:   mRd = mMask;
        5'h1A:   mRd = mStat;
        default: mRd = 16'h0000;
      endcase
    end
    mStat = ((rd && addr == 5'h1A) ? 16'h0000 : mStat) | evt;
    if (wr && addr == 5'h19) mMask = wd & 16'h8427;
    mPrev = lw;
    mBase = 1;
  endtask

  // One clock: model and design step on the edge, outputs compared at the falling edge
  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    chk("R9 irqN per-cycle", {15'd0, irqN}, {15'd0, ~|(mStat & mMask)});
    chk("R6 regRdData per-cycle", regRdData, mRd);
    rd = 0; wr = 0; ext = 3'b000;
  endtask

  task automatic rdReg(input logic [4:0] a, output logic [15:0] v);
    addr = a; rd = 1; tick(); v = regRdData;
  endtask

  task automatic wrReg(input logic [4:0] a, input logic [15:0] d);
    addr = a; wd = d; wr = 1; tick();
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset irqN", {15'd0, irqN}, 16'h0001);
    chk("R1 reset regRdData", regRdData, 16'h0000);
    rstN = 1;
    tick();                                   // baseline capture
    rdReg(5'h1A, v); chk("R1 no baseline event", v, 16'h0000);
    rdReg(5'h19, v); chk("R1 mask reset", v, 16'h0000);

    wrReg(5'h19, 16'hFFFF);
    rdReg(5'h19, v); chk("R10 mask legal bits", v, 16'h8427);

    lw = 16'h0002; tick();
    chk("R9 irq asserted", {15'd0, irqN}, 16'h0000);
    rdReg(5'h1A, v); chk("R2 link down event", v, 16'h0001);
    chk("R6 irq released after read", {15'd0, irqN}, 16'h0001);
    lw = 16'h0402; tick();
    rdReg(5'h1A, v); chk("R2 link up event", v, 16'h0001);

    lw = 16'h0404; tick();
    rdReg(5'h1A, v); chk("R3 speed 1000 to 2500", v, 16'h0002);
    lw = 16'h040C; tick();
    rdReg(5'h1A, v); chk("R4 duplex change", v, 16'h0004);
    lw = 16'h0000; tick();
    rdReg(5'h1A, v); chk("R2 R3 R4 combined change", v, 16'h0007);

    ext = 3'b011; tick();
    ext = 3'b100; tick();
    rdReg(5'h1A, v); chk("R5 pulse events", v, 16'h8420);

    ext = 3'b001; tick();
    addr = 5'h1A; rd = 1; ext = 3'b100; tick(); v = regRdData;
    chk("R7 read returns older bits", v, 16'h0400);
    rdReg(5'h1A, v); chk("R7 event kept across read", v, 16'h8000);
    rdReg(5'h1A, v); chk("R6 read cleared", v, 16'h0000);

    lw = 16'h4810; tick();
    rdReg(5'h1A, v); chk("R11 unrelated bits ignored", v, 16'h0000);

    wrReg(5'h19, 16'h0000);
    lw = 16'h4C10; tick();
    chk("R8 masked event no irq", {15'd0, irqN}, 16'h0001);
    wrReg(5'h19, 16'h0001);
    chk("R8 unmask raises irq at once", {15'd0, irqN}, 16'h0000);
    rdReg(5'h1A, v); chk("R8 masked bit latched", v, 16'h0001);

    rdReg(5'h18, v); chk("R10 live link word", v, 16'h4C10);
    rdReg(5'h05, v); chk("R10 unmapped reads zero", v, 16'h0000);
    ext = 3'b001; tick();
    wrReg(5'h1A, 16'h0000);
    wrReg(5'h18, 16'hFFFF);
    rdReg(5'h1A, v); chk("R10 write to pending ignored", v, 16'h0400);
    rdReg(5'h18, v); chk("R10 write to link ignored", v, 16'h4C10);
    rdReg(5'h19, v); chk("R10 mask kept", v, 16'h0001);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule